// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block is the register front end for four 12-bit analog output channels. A simple register bus writes a shadow data register per channel, a shadow range word that holds one polarity bit and one gain bit per channel, and a mode register with a global enable and a buffered-mode bit. The active codes and the active range settings feed an external converter. The active values change only when the bus reads one of two commit addresses. One commit address copies all four shadow codes at once. The other commit address copies the shadow range word.

When buffered mode is off, a data write also goes straight to the active code of its channel, while the range settings still wait for their commit read. When the global enable is clear, the active codes and ranges are forced to zero, which means unipolar and gain 0, and the commit reads do nothing. The shadow registers keep their contents the whole time. The bus is a valid/ready request channel. `bus_ready` rises in the first cycle after reset and then stays high, so there is no back-pressure. A request is taken in any cycle where both `bus_valid` and `bus_ready` are high.

Top module: `dac_dbuf_bank`

## Requirements
- R1: During and after reset, `dac_en` is 0 and every code, polarity and gain output is 0.
- R2: A write to byte address 0x02 sets the mode. Bit 1 is the global enable and drives `dac_en` from the next cycle. Bit 0 selects buffered mode.
- R3: A write to address 0x12 stores only the shadow range word. Bits 7-k select bipolar and bits 11-k select gain 1 for channel k, where k=0..3 stands for channels A..D. The outputs `dac_bipolar[k]` and `dac_gain[k]` do not change on this write.
- R4: A read of address 0x12 while enabled copies the shadow range word to `dac_bipolar` and `dac_gain` in the next cycle.
- R5: In buffered mode, a write to address 0x14+2k stores the shadow code of channel k and leaves every output unchanged.
- R6: A read of address 0x02 while enabled copies all four shadow codes to `dac_code` together in the next cycle. Channel k occupies bits [12k+11:12k].
- R7: With buffered mode off and the enable set, a data write to channel k updates that channel's active code in the next cycle and leaves the other channels unchanged.
- R8: While the enable is clear, all codes and ranges read 0 and commit reads have no effect. Shadow contents written before or during this time survive, and a commit after re-enabling delivers them.
- R9: Only bits [11:0] of a data write are kept. Bits [15:12] are ignored.
- R10: After the mode register and the range word are written with zero and the range commit is read, all outputs are disabled, unipolar and gain 0.
- R11: `bus_ready` is 0 in reset and 1 from the first cycle after reset. A read of any address other than 0x02 and 0x12 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted when high |
| bus_write | input | 1 | 1 means write, 0 means read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data |
| dac_en | output | 1 | Global enable as seen by the converter |
| dac_code | output | 48 | Active codes, channel k at [12k+11:12k] |
| dac_bipolar | output | 4 | Active polarity per channel, 1 means bipolar |
| dac_gain | output | 4 | Active gain select per channel |

## Verification
The hardest states to reach are the ones where the shadow and active copies differ while the mode changes under them. Examples are data written while disabled and then committed after re-enabling, and a direct write in unbuffered mode followed by a commit of older shadows. Directed steps build these states on purpose. A long run with a fixed seed then mixes data writes whose upper bits are set, mode changes, range writes, commit reads and reads of other addresses, so that these overlaps also occur in many unplanned orders. A bench model checks every output after every request.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;
  localparam int OFS_MODE   = 'h02;  // write: mode, read: commit codes
  localparam int OFS_RANGE  = 'h12;  // write: range word, read: commit ranges
  localparam int OFS_DATA0  = 'h14;  // first channel data, stride 2
  localparam int EN_BIT     = 1;
  localparam int BUF_BIT    = 0;
  localparam int BIP_LSB    = 4;
  localparam int GAIN_LSB   = 8;
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
  import dac_regs_pkg::*;
#(
  parameter int CH_N   = 4,
  parameter int ADDR_W = 6
) (
  input  logic              req_fire,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mode_we,
  output logic              range_we,
  output logic [CH_N-1:0]   data_we,
  output logic              code_commit,
  output logic              range_commit
);
  logic wr_fire, rd_fire;
  assign wr_fire = req_fire && req_write;
  assign rd_fire = req_fire && !req_write;

  assign mode_we      = wr_fire && (req_addr == ADDR_W'(OFS_MODE));
  assign range_we     = wr_fire && (req_addr == ADDR_W'(OFS_RANGE));
  assign code_commit  = rd_fire && (req_addr == ADDR_W'(OFS_MODE));
  assign range_commit = rd_fire && (req_addr == ADDR_W'(OFS_RANGE));

  for (genvar k = 0; k < CH_N; k++) begin : g_dec
    assign data_we[k] = wr_fire && (req_addr == ADDR_W'(OFS_DATA0 + 2 * k));
  end
endmodule

// File: rtl/dac_channel_slot.sv
module dac_channel_slot #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              direct,
  input  logic              wr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              commit,
  output logic [CODE_W-1:0] active
);
  logic [CODE_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (wr) begin
      shadow_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (!enable) begin
      active_q <= '0;
    end else if (commit) begin
      active_q <= shadow_q;
    end else if (wr && direct) begin
      active_q <= wdata;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/dac_range_bank.sv
module dac_range_bank #(
  parameter int CH_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            wr,
  input  logic [CH_N-1:0] bip_field,
  input  logic [CH_N-1:0] gain_field,
  input  logic            commit,
  output logic [CH_N-1:0] bipolar,
  output logic [CH_N-1:0] gain
);
  logic [CH_N-1:0] sh_bip_q, sh_gain_q, act_bip_q, act_gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_bip_q  <= '0;
      sh_gain_q <= '0;
    end else if (wr) begin
      sh_bip_q  <= bip_field;
      sh_gain_q <= gain_field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_bip_q  <= '0;
      act_gain_q <= '0;
    end else if (!enable) begin
      act_bip_q  <= '0;
      act_gain_q <= '0;
    end else if (commit) begin
      act_bip_q  <= sh_bip_q;
      act_gain_q <= sh_gain_q;
    end
  end

  // The field's most significant bit belongs to the first channel
  for (genvar k = 0; k < CH_N; k++) begin : g_map
    assign bipolar[k] = enable && act_bip_q[CH_N-1-k];
    assign gain[k]    = enable && act_gain_q[CH_N-1-k];
  end
endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
  import dac_regs_pkg::*;
#(
  parameter int CH_N   = 4,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  output logic                   bus_ready,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic                   dac_en,
  output logic [CH_N*CODE_W-1:0] dac_code,
  output logic [CH_N-1:0]        dac_bipolar,
  output logic [CH_N-1:0]        dac_gain
);
  logic            ready_q, en_q, buf_mode;
  logic            mode_we, range_we, code_commit, range_commit;
  logic [CH_N-1:0] data_we;
  logic            unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign bus_ready = ready_q;

  dac_bus_decode #(.CH_N(CH_N), .ADDR_W(ADDR_W)) dec_i (
    .req_fire     (bus_valid && ready_q),
    .req_write    (bus_write),
    .req_addr     (bus_addr),
    .mode_we      (mode_we),
    .range_we     (range_we),
    .data_we      (data_we),
    .code_commit  (code_commit),
    .range_commit (range_commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      buf_mode <= 1'b0;
    end else if (mode_we) begin
      en_q     <= bus_wdata[EN_BIT];
      buf_mode <= bus_wdata[BUF_BIT];
    end
  end
  assign dac_en = en_q;

  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    logic [CODE_W-1:0] act;
    dac_channel_slot #(.CODE_W(CODE_W)) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (en_q),
      .direct (!buf_mode),
      .wr     (data_we[k]),
      .wdata  (bus_wdata[CODE_W-1:0]),
      .commit (code_commit),
      .active (act)
    );
    assign dac_code[k*CODE_W +: CODE_W] = en_q ? act : '0;
  end

  dac_range_bank #(.CH_N(CH_N)) rng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (en_q),
    .wr         (range_we),
    .bip_field  (bus_wdata[BIP_LSB +: CH_N]),
    .gain_field (bus_wdata[GAIN_LSB +: CH_N]),
    .commit     (range_commit),
    .bipolar    (dac_bipolar),
    .gain       (dac_gain)
  );
endmodule

// File: rtl/dac_dbuf_bank_chk.sv
module dac_dbuf_bank_chk
  import dac_regs_pkg::*;
#(
  parameter int CH_N   = 4,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_ready,
  input logic                   bus_write,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic                   dac_en,
  input logic [CH_N*CODE_W-1:0] dac_code,
  input logic [CH_N-1:0]        dac_bipolar,
  input logic [CH_N-1:0]        dac_gain,
  input logic                   buffered
);
  logic fire, data_hit, code_rd, rng_rd;
  assign fire     = bus_valid && bus_ready;
  assign data_hit = fire && bus_write && !bus_addr[0] &&
                    (bus_addr >= ADDR_W'(OFS_DATA0)) &&
                    (bus_addr < ADDR_W'(OFS_DATA0 + 2 * CH_N));
  assign code_rd  = fire && !bus_write && (bus_addr == ADDR_W'(OFS_MODE));
  assign rng_rd   = fire && !bus_write && (bus_addr == ADDR_W'(OFS_RANGE));

  assert_ready_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bus_ready);

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_en && !data_hit && !code_rd) |=> (!dac_en || $stable(dac_code)));

  assert_range_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_en && !rng_rd) |=> (!dac_en || ($stable(dac_bipolar) && $stable(dac_gain))));

  // direct path to channel 0 keeps only the low code bits (R9)
  assert_direct_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bus_write && bus_addr == ADDR_W'(OFS_DATA0) && dac_en && !buffered)
    |=> dac_code[CODE_W-1:0] == $past(bus_wdata[CODE_W-1:0]));
endmodule

bind dac_dbuf_bank dac_dbuf_bank_chk #(
  .CH_N(CH_N), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .dac_en(dac_en), .dac_code(dac_code), .dac_bipolar(dac_bipolar),
  .dac_gain(dac_gain), .buffered(buf_mode)
);

// File: tb/dac_dbuf_bank_tb.sv
module dac_dbuf_bank_tb_top;
  localparam int CH_N = 4;
  localparam int CW   = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        dac_en;
  logic [47:0] dac_code;
  logic [3:0]  dac_bipolar, dac_gain;

  int n_tests = 0;
  int n_fail  = 0;

  logic [11:0] m_sh [4];
  logic [11:0] m_code [4];
  logic [3:0]  m_sh_bip, m_sh_gain, m_bip, m_gain;
  logic        m_en, m_buf;

  always #5 clk = ~clk;

  dac_dbuf_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .dac_en(dac_en), .dac_code(dac_code), .dac_bipolar(dac_bipolar),
    .dac_gain(dac_gain)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " en"}, 32'(dac_en), 32'(m_en));
    for (int k = 0; k < CH_N; k++)
      check({tag, " code"}, 32'(dac_code[k*CW +: CW]), 32'(m_code[k]));
    check({tag, " bipolar"}, 32'(dac_bipolar), 32'(m_bip));
    check({tag, " gain"}, 32'(dac_gain), 32'(m_gain));
  endtask

  // expected effect of one accepted request, from the requirements
  task automatic model(logic wr, logic [5:0] a, logic [15:0] d);
    if (wr) begin
      if (a == 6'h02) begin
        m_en = d[1]; m_buf = d[0];
        if (!m_en) begin
          for (int k = 0; k < CH_N; k++) m_code[k] = '0;
          m_bip = '0; m_gain = '0;
        end
      end else if (a == 6'h12) begin
        for (int k = 0; k < CH_N; k++) begin
          m_sh_bip[k]  = d[7-k];
          m_sh_gain[k] = d[11-k];
        end
      end else begin
        for (int k = 0; k < CH_N; k++)
          if (a == 6'(8'h14 + 2*k)) begin
            m_sh[k] = d[11:0];
            if (m_en && !m_buf) m_code[k] = d[11:0];
          end
      end
    end else if (m_en) begin
      if (a == 6'h02) for (int k = 0; k < CH_N; k++) m_code[k] = m_sh[k];
      if (a == 6'h12) begin m_bip = m_sh_bip; m_gain = m_sh_gain; end
    end
  endtask

  task automatic bus_op(logic wr, logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    model(wr, a, d);
  endtask

  initial begin
    for (int k = 0; k < CH_N; k++) begin m_sh[k] = '0; m_code[k] = '0; end
    m_sh_bip = '0; m_sh_gain = '0; m_bip = '0; m_gain = '0;
    m_en = 1'b0; m_buf = 1'b0;
    void'($urandom(32'h5eed_0042));

    #1;
    check("R11 ready in reset", 32'(bus_ready), 0);
    check_all("R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 ready after reset", 32'(bus_ready), 1);
    check_all("R1 after reset");

    bus_op(1, 6'h02, 16'h0003);
    check("R2 enable", 32'(dac_en), 1);
    bus_op(1, 6'h14, 16'hF123);
    check_all("R5 buffered write holds");
    bus_op(1, 6'h16, 16'h0456);
    bus_op(1, 6'h18, 16'h0789);
    bus_op(1, 6'h1A, 16'h0ABC);
    check_all("R5 buffered writes hold");
    bus_op(0, 6'h02, 16'h0);
    check_all("R6 commit all codes");
    check("R9 upper bits dropped", 32'(dac_code[11:0]), 32'h123);
    check("R6 channel D code", 32'(dac_code[47:36]), 32'hABC);

    bus_op(1, 6'h12, 16'h0A50);
    check("R3 range write no effect bip", 32'(dac_bipolar), 0);
    check("R3 range write no effect gain", 32'(dac_gain), 0);
    bus_op(0, 6'h12, 16'h0);
    check("R4 bipolar after commit", 32'(dac_bipolar), 32'b1010);
    check("R4 gain after commit", 32'(dac_gain), 32'b0101);
    bus_op(0, 6'h04, 16'h0);
    check_all("R11 other read no effect");

    bus_op(1, 6'h02, 16'h0002);
    bus_op(1, 6'h18, 16'h3DEF);
    check("R7 direct write ch C", 32'(dac_code[35:24]), 32'hDEF);
    check_all("R7 others unchanged");

    bus_op(1, 6'h02, 16'h0000);
    check_all("R8 disabled zero");
    bus_op(1, 6'h16, 16'h0777);
    bus_op(0, 6'h02, 16'h0);
    bus_op(0, 6'h12, 16'h0);
    check("R8 commit ignored while off", 32'(dac_code), 0);
    check_all("R8 off");
    bus_op(1, 6'h02, 16'h0003);
    check("R8 re-enable stays zero", 32'(dac_code), 0);
    bus_op(0, 6'h02, 16'h0);
    check("R8 shadow kept ch B", 32'(dac_code[23:12]), 32'h777);
    check_all("R8 after re-enable commit");

    bus_op(1, 6'h12, 16'h0000);
    bus_op(0, 6'h12, 16'h0);
    bus_op(1, 6'h02, 16'h0000);
    check("R10 cleared bip", 32'(dac_bipolar), 0);
    check("R10 cleared gain", 32'(dac_gain), 0);
    check("R10 disabled", 32'(dac_en), 0);

    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [5:0] a;
      logic [15:0] d;
      sel = int'($urandom_range(0, 9));
      d   = 16'($urandom);
      case (sel)
        0:       bus_op(1, 6'h02, {14'h0, 2'($urandom_range(0, 3))});
        1:       bus_op(1, 6'h12, d);
        2, 3, 4: bus_op(1, 6'(8'h14 + 2*$urandom_range(0, 3)), d);
        5, 6:    bus_op(0, 6'h02, d);
        7:       bus_op(0, 6'h12, d);
        default: begin
          a = 6'($urandom_range(0, 63));
          bus_op(0, (a == 6'h02 || a == 6'h12) ? 6'h06 : a, d);
        end
      endcase
      check_all("R6/R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule